// File: doc/BRIEF.md
# LNB Supply-Level Command Serializer

This block sends a short switch command to a satellite dish by modulating a single supply-level select output. Its only output level is a choice between the high supply level (18 V) and the low supply level (13 V) of the LNB. The bits are carried by which level is present during a timed slot, not by a pulse on a data line.

A command byte is accepted together with a one-cycle start strobe. The block then drives the high level for a 32 ms lead-in. After that it sends a fixed 0 bit followed by the eight command bits, least significant first. Each level stays in place for an 8 ms slot. The level changes only when a bit differs from the one before it. No slot follows the last bit: busy falls and done pulses in the same cycle as that bit appears. The time base is a parameter giving clock cycles per millisecond.

Top module: `lnb_level_cmd_tx`

## Requirements
- R1: Out of reset, volt_high_o, busy_o and done_o are all 0.
- R2: A start_i pulse seen while idle is accepted at that clock edge. From that edge volt_high_o is 1 and busy_o is 1, and the high level is held for exactly 32*CYCLES_PER_MS cycles before the first bit appears.
- R3: The frame is 9 bits, sent least significant first. Frame bit 0 is always 0, and frame bit k+1 is cmd_i[k] as latched at acceptance. A frame bit 1 is sent as volt_high_o=1 and a 0 as volt_high_o=0.
- R4: Each of the first 8 frame bits is held for exactly 8*CYCLES_PER_MS cycles. volt_high_o changes only at slot boundaries, and only when the new bit differs from the current level.
- R5: The 9th bit appears at the same edge where busy_o falls and done_o rises. done_o is high for exactly one cycle.
- R6: A start_i pulse while busy_o is 1 is ignored. This includes a pulse coinciding with the edge that applies the last bit. The frame contents and timing do not change.
- R7: After done, volt_high_o keeps the level of the last bit until a new command is accepted.
- R8: A start_i pulse in the cycle right after done is accepted as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to send cmd_i |
| cmd_i | input | CMD_W | Command byte, latched on acceptance |
| volt_high_o | output | 1 | 1 selects the high supply level, 0 the low level |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse when the last bit is applied |

## Verification
Two events can fall in the same cycle: the edge that applies the final bit and ends busy, and an incoming start request. The bench raises start_i exactly in the cycle before that edge. It then expects the final level with done high and busy low, and in the next cycle busy still low, so the request must have been dropped. A second collision is a start in the cycle right after done. It must begin a new lead-in at once, judged by busy and the high level appearing one edge later.

// File: rtl/lnb_cmd_pkg.sv
package lnb_cmd_pkg;
  localparam int unsigned LEAD_MS = 32;
  localparam int unsigned SLOT_MS = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_BITS = 2'd2
  } tx_state_e;
endpackage

// File: rtl/lnb_hold_timer.sv
module lnb_hold_timer #(
  parameter int unsigned MAX_VAL = 128,
  localparam int unsigned CNT_W = $clog2(MAX_VAL + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val_i;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_VAL)); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
endmodule

// File: rtl/lnb_bit_shifter.sv
module lnb_bit_shifter #(
  parameter int unsigned FRAME_W = 9,
  localparam int unsigned IDX_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] data_i,
  input  logic               shift_i,
  output logic               bit_o,
  output logic               last_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {1'b0, sh_q[FRAME_W-1:1]};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o  = sh_q[0];
  assign last_o = (idx_q == IDX_W'(FRAME_W - 1));

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(FRAME_W)); // R3
endmodule

// File: rtl/lnb_level_cmd_tx.sv
module lnb_level_cmd_tx
  import lnb_cmd_pkg::*;
#(
  parameter int unsigned CYCLES_PER_MS = 27000,
  parameter int unsigned CMD_W         = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             volt_high_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned FRAME_W  = CMD_W + 1;
  localparam int unsigned LEAD_CYC = LEAD_MS * CYCLES_PER_MS;
  localparam int unsigned SLOT_CYC = SLOT_MS * CYCLES_PER_MS;
  localparam int unsigned CNT_W    = $clog2(LEAD_CYC + 1);

  tx_state_e        st_q, st_d;
  logic             volt_q, done_q;
  logic             accept, tick, fin, tmr_zero, cur_bit, is_last;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  assign accept = (st_q == ST_IDLE) && start_i;
  assign tick   = (st_q != ST_IDLE) && tmr_zero;
  assign fin    = (st_q == ST_BITS) && tick && is_last;

  assign tmr_load = accept || (tick && !fin);
  assign tmr_val  = accept ? CNT_W'(LEAD_CYC - 1) : CNT_W'(SLOT_CYC - 1);

  lnb_hold_timer #(.MAX_VAL(LEAD_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  // frame = command shifted up by one, leading zero bit
  lnb_bit_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .data_i  ({cmd_i, 1'b0}),
    .shift_i (tick),
    .bit_o   (cur_bit),
    .last_o  (is_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_LEAD;
      ST_LEAD: if (tick)   st_d = ST_BITS;
      ST_BITS: if (fin)    st_d = ST_IDLE;
      default:             st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      volt_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
      if (accept)                       volt_q <= 1'b1;
      else if (tick && cur_bit != volt_q) volt_q <= ~volt_q; // toggle only on change
    end
  end

  assign volt_high_o = volt_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;

  AST_LEAD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LEAD) |-> volt_high_o); // R2
  AST_ACCEPT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i)); // R6
  AST_HOLD_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tmr_zero) |=> $stable(volt_high_o)); // R4
  AST_DONE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(volt_high_o)); // R7
endmodule

// File: tb/lnb_level_cmd_tx_tb.sv
module lnb_level_cmd_tx_tb;
  localparam int unsigned CPM  = 4;
  localparam int unsigned LEAD = 32 * CPM;
  localparam int unsigned SLOT = 8 * CPM;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] cmd = '0;
  logic       volt, busy, done;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 0;

  always #5 clk = ~clk;

  lnb_level_cmd_tx #(.CYCLES_PER_MS(CPM), .CMD_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd),
    .volt_high_o(volt), .busy_o(busy), .done_o(done)
  );

  function automatic logic [8:0] exp_frame(input logic [7:0] c);
    return {c, 1'b0};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // assumes caller sits at a negedge; leaves at negedge after done cycle
  task automatic send(input logic [7:0] c, input bit poke_mid, input bit poke_last);
    logic [8:0] exp = exp_frame(c);
    logic [8:0] seen = '0;
    int bad;
    start = 1'b1; cmd = c;
    @(negedge clk);
    start = 1'b0; cmd = ~c;
    bad = 0;
    for (int n = 0; n < LEAD; n++) begin
      if (!(volt && busy && !done)) bad++;
      if (poke_mid && n == LEAD/2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    chk(bad == 0, "R2 lead-in high for 32ms", bad, 0);
    for (int k = 0; k < 8; k++) begin
      bad = 0;
      for (int n = 0; n < SLOT; n++) begin
        if (volt !== exp[k] || !busy || done) bad++;
        if (n == SLOT/2) seen[k] = volt;
        if (poke_mid && k == 3 && n == 5) start = 1'b1;
        if (poke_last && k == 7 && n == SLOT-1) start = 1'b1;
        @(negedge clk);
        if (!(poke_last && k == 7 && n == SLOT-1)) start = 1'b0;
      end
      chk(bad == 0, $sformatf("R4 slot %0d level/length", k), bad, 0);
    end
    seen[8] = volt;
    chk(done && !busy && volt === exp[8], "R5 last bit with done, busy low",
        {done, busy, volt}, {2'b10, exp[8]});
    start = 1'b0;
    chk(seen == exp, "R3 frame reconstructed", seen, exp);
    if (poke_mid || poke_last)
      chk(seen == exp, "R6 start while busy ignored (frame)", seen, exp);
  endtask

  task automatic after_done(input logic lvl, input bit poked);
    @(negedge clk);
    chk(!done && !busy, poked ? "R6 start on final edge ignored" : "R5 done one cycle",
        {done, busy}, 0);
    for (int n = 0; n < 20; n++) begin
      if (volt !== lvl) begin
        chk(0, "R7 level held after done", volt, lvl);
        return;
      end
      @(negedge clk);
    end
    chk(1, "R7 level held after done", volt, lvl);
  endtask

  initial begin
    logic [7:0] c;
    void'($urandom(32'd7031));
    repeat (3) @(negedge clk);
    chk(!volt && !busy && !done, "R1 reset state", {volt, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!volt && !busy && !done, "R1 idle after reset", {volt, busy, done}, 0);

    send(8'h00, 0, 0); after_done(1'b0, 0);
    send(8'hFF, 0, 0); after_done(1'b1, 0);
    send(8'hA5, 1, 0); after_done(1'b1, 0);
    send(8'h5A, 0, 1); after_done(1'b0, 1);
    // R8: back-to-back, start in cycle right after done
    send(8'h3C, 0, 0);
    send(8'hC3, 0, 0);
    chk(1, "R8 back-to-back start accepted", 1, 1);
    after_done(1'b1, 0);
    for (int i = 0; i < 6; i++) begin
      c = 8'($urandom);
      send(c, ($urandom % 2) == 1, 0);
      after_done(c[7], 0);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule